// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This execution unit takes one instruction word per cycle with a valid strobe and two 64-bit operand values. It decodes the word into operation flags, checks that the operands lie in the range the operation allows, and multiplies them. It then adds the product to, or subtracts it from, either zero or an accumulator held in a HI/LO register pair. Optionally it clamps the result, stores it back into HI/LO, and asks for a register write of HI or LO.

Two instruction families are recognised. The first always accumulates and has a saturation flag, which also switches both operands to 16-bit range. It has a single layout (HI low word over LO low word) and a double layout (all 64 bits of LO). The second family covers plain multiply, negated multiply, multiply-add and multiply-subtract. It always uses the single layout and never saturates. All results show up on registered outputs one clock after the instruction is accepted.

Top module: `mac_sat_unit`

## Requirements
- R1: A word with bits 31:26 zero, bits 8:7 zero and bits 5:1 = 10100 belongs to family A. In that word rs is 25:21, rt is 20:16, rd is 15:11, the saturate flag is bit 10, the HI-select flag is bit 9 and the unsigned flag is bit 6. Bit 0 = 1 selects the double layout. Family A always accumulates, never subtracts, and uses 16-bit operands exactly when the saturate flag is set.
- R2: A word with bits 31:26 zero, bit 10 zero, bits 5:1 = 01100 and bit 6 = 1 belongs to family B. Bit 9 is the HI-select flag and bit 0 is the unsigned flag. Bit 8 selects accumulate (1) or zero (0) as the left-hand side, and bit 7 selects subtract (1) or add (0). Family B uses the single layout with 32-bit operands and no saturation.
- R3: A valid word that matches neither family raises out_illegal one cycle later. It leaves HI and LO unchanged and requests no write.
- R4: Operand range rules: with 32-bit operands each operand must equal the sign extension of its low 32 bits. With 16-bit unsigned operands each must equal its low 16 bits zero-extended. With 16-bit signed operands each must equal its low 16 bits sign-extended. A violation raises out_err.
- R5: The product is taken modulo 2^64. It uses operands zero-extended from 32 bits when the unsigned flag is set, and operands sign-extended from 32 bits otherwise.
- R6: The accumulated value is {HI[31:0], LO[31:0]} in the single layout and LO in the double layout. The result is that value plus or minus the product, modulo 2^64.
- R7: With signed saturation, a result that differs from the sign extension of its low 32 bits is clamped. A negative result becomes 0xFFFFFFFF80000000 and a positive one becomes 0x000000007FFFFFFF.
- R8: With unsigned saturation, a result whose upper 32 bits are not all zero becomes all ones.
- R9: In the double layout LO takes the result and HI keeps its value. In the single layout LO takes the sign-extended low 32 bits and HI takes the sign-extended upper 32 bits.
- R10: For an accepted legal instruction with rd nonzero, wb_en is raised with wb_idx = rd and wb_data = the new HI when the HI-select flag is set, otherwise the new LO. With rd = 0 no write is requested.
- R11: An instruction that raises out_err leaves HI and LO unchanged and requests no write.
- R12: Synchronous reset clears HI, LO and all output strobes. Outputs respond one cycle after in_valid, and a cycle without in_valid produces no out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 32 | Instruction word |
| in_opa | input | 64 | First source operand value |
| in_opb | input | 64 | Second source operand value |
| out_valid | output | 1 | Result of an accepted instruction is present |
| out_err | output | 1 | Operand out of range |
| out_illegal | output | 1 | Word matched no family |
| wb_en | output | 1 | Register write request |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Value to write |
| acc_hi | output | 64 | HI register |
| acc_lo | output | 64 | LO register |

## Verification
The hardest cases to reach from the ports are the clamp paths. They need an accumulator already sitting just inside the 32-bit limit, positive or negative, before one more short product pushes it across. The stimulus first loads HI/LO with a plain family-B multiply whose result lands near the limit. A short saturating family-A accumulate then crosses it. The double layout is reached the same way: LO is preloaded by a single-layout operation, and a double accumulate must then ignore HI.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic       legal;
    logic       accum;
    logic       sub;
    logic       uns;
    logic       sat;
    logic       shrt;
    logic       dbl;
    logic       sel_hi;
    logic [4:0] rd;
  } mac_ctl_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] instr,
  output mac_ctl_t      ctl
);
  logic fam_a, fam_b;

  always_comb begin
    fam_a = (instr[31:26] == 6'd0) && (instr[8:7] == 2'b00) && (instr[5:1] == 5'b10100);
    fam_b = (instr[31:26] == 6'd0) && !instr[10] && instr[6] && (instr[5:1] == 5'b01100);
    ctl        = '0;
    ctl.legal  = fam_a || fam_b;
    ctl.rd     = instr[15:11];
    ctl.sel_hi = instr[9];
    if (fam_a) begin
      ctl.accum = 1'b1;
      ctl.sub   = 1'b0;
      ctl.uns   = instr[6];
      ctl.sat   = instr[10];
      ctl.shrt  = instr[10];
      ctl.dbl   = instr[0];
    end else if (fam_b) begin
      ctl.accum = instr[8];
      ctl.sub   = instr[7];
      ctl.uns   = instr[0];
    end
  end
endmodule

// File: rtl/mac_opcheck.sv
module mac_opcheck #(
  parameter int XLEN = 64,
  parameter int NW   = 32,
  parameter int SW   = 16
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            shrt,
  input  logic            uns,
  output logic            ok
);
  localparam int NOPS = 2;
  logic [NOPS-1:0][XLEN-1:0] ops;
  logic [NOPS-1:0]           fit;

  assign ops[0] = opa;
  assign ops[1] = opb;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    logic [XLEN-1:0] canon;
    always_comb begin
      if (!shrt)     canon = {{(XLEN-NW){ops[i][NW-1]}}, ops[i][NW-1:0]};
      else if (uns)  canon = {{(XLEN-SW){1'b0}}, ops[i][SW-1:0]};
      else           canon = {{(XLEN-SW){ops[i][SW-1]}}, ops[i][SW-1:0]};
      fit[i] = (canon == ops[i]);
    end
  end

  assign ok = &fit;
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  mac_ctl_t        ctl,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] lo,
  output logic [XLEN-1:0] nxt_hi,
  output logic [XLEN-1:0] nxt_lo
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] xa, xb, prod, lhs, sum, res;
  logic            s_ovf, u_ovf;

  always_comb begin
    if (ctl.uns) begin
      xa = {{HALF{1'b0}}, opa[HALF-1:0]};
      xb = {{HALF{1'b0}}, opb[HALF-1:0]};
    end else begin
      xa = {{HALF{opa[HALF-1]}}, opa[HALF-1:0]};
      xb = {{HALF{opb[HALF-1]}}, opb[HALF-1:0]};
    end
    prod = xa * xb;
    if (!ctl.accum)   lhs = '0;
    else if (ctl.dbl) lhs = lo;
    else              lhs = {hi[HALF-1:0], lo[HALF-1:0]};
    sum = ctl.sub ? (lhs - prod) : (lhs + prod);

    s_ovf = (sum != {{HALF{sum[HALF-1]}}, sum[HALF-1:0]});
    u_ovf = |sum[XLEN-1:HALF];
    res   = sum;
    if (ctl.sat) begin
      if (!ctl.uns && s_ovf)
        res = sum[XLEN-1] ? {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}}
                          : {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
      else if (ctl.uns && u_ovf)
        res = '1;
    end

    if (ctl.dbl) begin
      nxt_lo = res;
      nxt_hi = hi;
    end else begin
      nxt_lo = {{HALF{res[HALF-1]}}, res[HALF-1:0]};
      nxt_hi = {{HALF{res[XLEN-1]}}, res[XLEN-1:HALF]};
    end
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IW   = 32,
  parameter int SW   = 16,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IW-1:0]   in_instr,
  input  logic [XLEN-1:0] in_opa,
  input  logic [XLEN-1:0] in_opb,
  output logic            out_valid,
  output logic            out_err,
  output logic            out_illegal,
  output logic            wb_en,
  output logic [RW-1:0]   wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] acc_hi,
  output logic [XLEN-1:0] acc_lo
);
  localparam int HALF = XLEN / 2;

  mac_ctl_t        ctl;
  logic            ops_ok, commit;
  logic [XLEN-1:0] nxt_hi, nxt_lo;

  mac_decode #(.IW(IW)) u_dec (.instr(in_instr), .ctl(ctl));

  mac_opcheck #(.XLEN(XLEN), .NW(HALF), .SW(SW)) u_chk (
    .opa(in_opa), .opb(in_opb), .shrt(ctl.shrt), .uns(ctl.uns), .ok(ops_ok)
  );

  mac_datapath #(.XLEN(XLEN)) u_dp (
    .ctl(ctl), .opa(in_opa), .opb(in_opb), .hi(acc_hi), .lo(acc_lo),
    .nxt_hi(nxt_hi), .nxt_lo(nxt_lo)
  );

  assign commit = in_valid && ctl.legal && ops_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi      <= '0;
      acc_lo      <= '0;
      out_valid   <= 1'b0;
      out_err     <= 1'b0;
      out_illegal <= 1'b0;
      wb_en       <= 1'b0;
      wb_idx      <= '0;
      wb_data     <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && !ctl.legal;
      out_err     <= in_valid && ctl.legal && !ops_ok;
      wb_en       <= commit && (ctl.rd != '0);
      if (commit) begin
        acc_hi  <= nxt_hi;
        acc_lo  <= nxt_lo;
        wb_idx  <= ctl.rd[RW-1:0];
        wb_data <= ctl.sel_hi ? nxt_hi : nxt_lo;
      end
    end
  end
endmodule

// File: rtl/mac_sat_unit_chk.sv
module mac_sat_unit_chk #(
  parameter int XLEN = 64,
  parameter int RW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            out_valid,
  input logic            out_err,
  input logic            out_illegal,
  input logic            wb_en,
  input logic [RW-1:0]   wb_idx,
  input logic [XLEN-1:0] acc_hi,
  input logic [XLEN-1:0] acc_lo
);
  AST_ILLEGAL_HOLDS_ACC: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (acc_hi == $past(acc_hi)) && (acc_lo == $past(acc_lo)) && !wb_en); // R3
  AST_ERR_HOLDS_ACC: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (acc_hi == $past(acc_hi)) && (acc_lo == $past(acc_lo)) && !wb_en); // R11
  AST_WB_NONZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_idx != '0)); // R10
  AST_ERR_ILLEGAL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(out_err && out_illegal)); // R3
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !wb_en && !out_err && !out_illegal && $stable(acc_hi) && $stable(acc_lo)); // R12
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (acc_hi == '0) && (acc_lo == '0) && !out_valid); // R12
endmodule

bind mac_sat_unit mac_sat_unit_chk #(.XLEN(XLEN), .RW(RW)) u_chk_bind (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_err(out_err),
  .out_illegal(out_illegal), .wb_en(wb_en), .wb_idx(wb_idx),
  .acc_hi(acc_hi), .acc_lo(acc_lo)
);

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [63:0] in_opa = '0, in_opb = '0;
  logic        out_valid, out_err, out_illegal, wb_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data, acc_hi, acc_lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_sat_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_opa(in_opa), .in_opb(in_opb), .out_valid(out_valid), .out_err(out_err),
    .out_illegal(out_illegal), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  typedef struct {
    string       tag;
    logic        err, ill, wen;
    logic [4:0]  idx;
    logic [63:0] wdat, hi, lo;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  logic [63:0] m_hi = '0, m_lo = '0;
  bit          done = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [31:0] enc_a(logic [4:0] rd, logic sat, logic sh, logic un, logic dbl);
    return {6'b0, 5'd1, 5'd2, rd, sat, sh, 2'b00, un, 5'b10100, dbl};
  endfunction

  function automatic logic [31:0] enc_b(logic [4:0] rd, logic sh, logic [2:0] op, logic un);
    return {6'b0, 5'd3, 5'd4, rd, 1'b0, sh, op, 5'b01100, un};
  endfunction

  // Reference model built from the requirements
  task automatic send(string tag, logic [31:0] w, logic [63:0] a, logic [63:0] b);
    exp_t e;
    logic fa, fb, acc, sub, un, sat, sh, dbl, sel, ok;
    logic [63:0] ca, cb, xa, xb, p, l, r;
    fa = (w[31:26] == 0) && (w[8:7] == 0) && (w[5:1] == 5'b10100);
    fb = (w[31:26] == 0) && !w[10] && w[6] && (w[5:1] == 5'b01100);
    acc = fa ? 1'b1 : w[8];
    sub = fa ? 1'b0 : w[7];
    un  = fa ? w[6] : w[0];
    sat = fa ? w[10] : 1'b0;
    sh  = sat;
    dbl = fa ? w[0] : 1'b0;
    sel = w[9];
    if (!sh) begin ca = sx32(a); cb = sx32(b); end
    else if (un) begin ca = {48'd0, a[15:0]}; cb = {48'd0, b[15:0]}; end
    else begin ca = {{48{a[15]}}, a[15:0]}; cb = {{48{b[15]}}, b[15:0]}; end
    ok = (ca == a) && (cb == b);
    e.tag = tag;
    e.ill = !(fa || fb);
    e.err = !e.ill && !ok;
    e.wen = 1'b0; e.idx = 'x; e.wdat = 'x;
    if (!e.ill && ok) begin
      xa = un ? {32'd0, a[31:0]} : sx32(a);
      xb = un ? {32'd0, b[31:0]} : sx32(b);
      p  = xa * xb;
      l  = !acc ? 64'd0 : (dbl ? m_lo : {m_hi[31:0], m_lo[31:0]});
      r  = sub ? l - p : l + p;
      if (sat && !un && (sx32(r) != r)) r = r[63] ? 64'hFFFFFFFF80000000 : 64'h000000007FFFFFFF;
      else if (sat && un && (r[63:32] != 0)) r = '1;
      if (dbl) m_lo = r;
      else begin m_lo = sx32(r); m_hi = {{32{r[63]}}, r[63:32]}; end
      if (w[15:11] != 0) begin
        e.wen = 1'b1; e.idx = w[15:11]; e.wdat = sel ? m_hi : m_lo;
      end
    end
    e.hi = m_hi; e.lo = m_lo;
    sb.push_back(e);
    in_valid = 1'b1; in_instr = w; in_opa = a; in_opb = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard when a result appears
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) chk("R12", "unexpected out_valid", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "out_illegal", {63'd0, out_illegal}, {63'd0, e.ill});
        chk(e.tag, "out_err", {63'd0, out_err}, {63'd0, e.err});
        chk(e.tag, "wb_en", {63'd0, wb_en}, {63'd0, e.wen});
        if (e.wen) begin
          chk(e.tag, "wb_idx", {59'd0, wb_idx}, {59'd0, e.idx});
          chk(e.tag, "wb_data", wb_data, e.wdat);
        end
        chk(e.tag, "acc_hi", acc_hi, e.hi);
        chk(e.tag, "acc_lo", acc_lo, e.lo);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "reset hi", acc_hi, 64'd0);
    chk("R12", "reset lo", acc_lo, 64'd0);
    chk("R12", "reset valid", {63'd0, out_valid}, 64'd0);
    // R2 signed multiply, write LO
    send("R2", enc_b(5'd5, 1'b0, 3'b001, 1'b0), -64'sd3, 64'd7);
    // R5 unsigned multiply of 0xFFFFFFFF values, write HI
    send("R5", enc_b(5'd6, 1'b1, 3'b001, 1'b1), '1, '1);
    // R6 multiply-add, multiply-subtract, negate
    send("R6", enc_b(5'd7, 1'b0, 3'b101, 1'b0), 64'd1000, 64'd3);
    send("R6", enc_b(5'd7, 1'b1, 3'b111, 1'b0), 64'd20, -64'sd5);
    send("R2", enc_b(5'd8, 1'b0, 3'b011, 1'b0), 64'd12, 64'd11);
    // idle cycles: no output
    repeat (2) @(negedge clk);
    chk("R12", "idle valid", {63'd0, out_valid}, 64'd0);
    // R7 positive clamp
    send("R2", enc_b(5'd0, 1'b0, 3'b001, 1'b0), 64'h7FFFFFF0, 64'd1);
    send("R7", enc_a(5'd9, 1'b1, 1'b0, 1'b0, 1'b0), 64'h100, 64'h100);
    // R8 unsigned clamp
    send("R8", enc_a(5'd9, 1'b1, 1'b1, 1'b1, 1'b0), 64'hFFFF, 64'hFFFF);
    // R7 negative clamp
    send("R2", enc_b(5'd0, 1'b0, 3'b001, 1'b0), 64'hFFFFFFFF80000010, 64'd1);
    send("R7", enc_a(5'd10, 1'b1, 1'b1, 1'b0, 1'b0), -64'sd256, 64'd256);
    // R1 non-saturating family A, no clamp needed, rd=0
    send("R1", enc_a(5'd0, 1'b0, 1'b0, 1'b0, 1'b0), 64'd2, 64'd3);
    // R9 double layout: LO full, HI unchanged
    send("R2", enc_b(5'd0, 1'b0, 3'b001, 1'b0), 64'h40000000, 64'd8);
    send("R9", enc_a(5'd11, 1'b0, 1'b1, 1'b0, 1'b1), 64'h40000000, 64'd4);
    send("R9", enc_a(5'd12, 1'b0, 1'b0, 1'b1, 1'b1), '1, 64'd2);
    // R4 range errors and R11 no update
    send("R4", enc_a(5'd13, 1'b1, 1'b0, 1'b0, 1'b0), 64'h10000, 64'd1);
    send("R4", enc_a(5'd13, 1'b1, 1'b0, 1'b1, 1'b0), 64'hFFFFFFFFFFFFFFFF, 64'd1);
    send("R11", enc_b(5'd14, 1'b0, 3'b101, 1'b0), 64'h0000000100000000, 64'd1);
    send("R4", enc_b(5'd14, 1'b0, 3'b001, 1'b1), 64'h00000000FFFFFFFF, 64'd1);
    // R3 illegal words
    send("R3", 32'hFFFFFFFF, 64'd1, 64'd1);
    send("R3", enc_b(5'd15, 1'b0, 3'b000, 1'b0), 64'd1, 64'd1);
    send("R3", enc_a(5'd15, 1'b0, 1'b0, 1'b0, 1'b0) | 32'h0000_0080, 64'd1, 64'd1);
    // R10 write HI select after legal op
    send("R10", enc_b(5'd31, 1'b1, 3'b101, 1'b0), -64'sd9, 64'd9);
    send("R10", enc_b(5'd0, 1'b1, 3'b001, 1'b0), 64'd5, 64'd5);
    repeat (3) @(negedge clk);
    if (sb.size() != 0) chk("R12", "pending results", sb.size(), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule